// File: doc/BRIEF.md
# Audio DMA Channel Register Block

This block holds the software-visible registers of one bus-master audio DMA channel and produces that channel's interrupt. Software reaches the registers through a small byte/word/dword access port that covers a 16-byte window. The descriptor-fetch and data-movement engine is a separate block. It reads the list base address, the current index, the last valid index and the run state from this block. It reports its progress back as single-cycle event inputs: a descriptor step, a buffer-completion interrupt, reaching the last valid buffer, a FIFO error and a new remaining-sample count.

The status register holds two kinds of bits. Three event bits are cleared by writing one. Two state bits can be changed only by hardware. The control register holds a run bit, a self-clearing channel reset command and three interrupt enables. Writing the last valid index while the channel is running but halted restarts it. Setting the run bit from the stopped state sends a start pulse to the engine and moves the prefetch index forward. The `irq` output is a registered level signal and serves as this channel's bit in a global interrupt summary.

Top module: `adma_chan_regs`

## Requirements
- R1: After reset, status reads 0x0001 (halted only), every other register reads zero, and `irq`, `dma_run`, `dma_start` and `dma_stop` are low.
- R2: A dword write at offset 0 stores bits 31:2 as the list base. Bits 1:0 always read zero. Byte and word writes to offset 0 have no effect.
- R3: Status bit positions are: bit 0 halted, bit 1 current-equals-last, bit 2 last-buffer interrupt, bit 3 completion interrupt, bit 4 FIFO error. A byte or word write at offset 6 clears each of bits 4:2 where the data bit is 1 and leaves the rest alone. Bits 1:0 are never changed by that write. Bits 15:5 read zero.
- R4: When an event sets a status bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R5: `ev_ioc` sets bit 3. `ev_lvb` sets bits 2, 1 and 0. `ev_fifoe` sets bit 4. `ev_step` copies the prefetch index into the current index and adds one to the prefetch index, modulo 32. `ev_cnt_ld` loads `ev_cnt` into the count.
- R6: `irq` is updated at the same clock edge that updates status or control. It is 1 exactly when (bit 2 and control bit 2) or (bit 3 and control bit 3) is true. The FIFO error bit never raises `irq`.
- R7: A byte write at offset 11 stores data bits 4:0 into control when bit 1 is clear. Bit 0 is run, bit 2 enables the last-buffer interrupt, bit 3 enables the completion interrupt and bit 4 enables the FIFO-error interrupt. `dma_run` follows bit 0.
- R8: A control write that sets run while run is clear adds one to the prefetch index (modulo 32) and pulses `dma_start` high for one cycle. Setting run when it is already set does neither. A control write with run clear, or with the reset command, pulses `dma_stop`.
- R9: A control write with bit 1 set is a channel reset, and it overrides any event in the same cycle. Base, indices and count become zero, status becomes 0x01, and control keeps only its previous bits 4:2.
- R10: A byte write at offset 5 stores the low 5 data bits as the last valid index. If run is set and the channel is halted, the same write also clears status bits 1:0 and adds one to the prefetch index (modulo 32). Otherwise it only stores the index.
- R11: Read data is right-justified and reads have no side effects. The readable fields are:
  - dword 0: the base.
  - dword 4: current index in 7:0, last valid index in 15:8 and status in 31:16.
  - dword 8: count in 15:0, prefetch index in 23:16 and control in 31:24.
  - bytes 4, 5, 6, 10 and 11: current index, last valid index, status, prefetch index and control.
  - words 6 and 8: status and count.
  - Any other access reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword |
| bus_off | input | 4 | Byte offset inside the channel window |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Right-justified read data (combinational) |
| ev_step | input | 1 | Engine moved to the next descriptor |
| ev_ioc | input | 1 | Completion interrupt event |
| ev_lvb | input | 1 | Last valid buffer finished; channel halts |
| ev_fifoe | input | 1 | FIFO error event |
| ev_cnt_ld | input | 1 | Load the remaining-sample count |
| ev_cnt | input | CNT_W | Count value to load |
| dma_base | output | 32 | Descriptor list base address |
| dma_cur | output | IDX_W | Current index |
| dma_last | output | IDX_W | Last valid index |
| dma_run | output | 1 | Run bit |
| dma_start | output | 1 | One-cycle start request |
| dma_stop | output | 1 | One-cycle stop request |
| irq | output | 1 | Registered interrupt level and summary bit |

## Verification
The directed part writes the status register with different data patterns: ones on the event bits only, ones on the state bits only, and clears that land on the same cycle as an event. Together these separate the three kinds of status bit and show the priority of a hardware set over a clear. Control writes are tried from the stopped state, from the running state and with the reset command. This separates a real start from a repeated run write, and a reset from a plain stop. Last-index writes are tried while halted and running, and while running but not halted, which separates a restart from a plain store. A long chain of descriptor steps checks the wrap of the prefetch index. A pseudo-random mix of all accesses and events follows, and the bench compares every output with its behavioural model on every clock.

// File: rtl/adma_chan_regs.sv
module adma_chan_regs #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [1:0]       bus_size,
  input  logic [3:0]       bus_off,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             ev_step,
  input  logic             ev_ioc,
  input  logic             ev_lvb,
  input  logic             ev_fifoe,
  input  logic             ev_cnt_ld,
  input  logic [CNT_W-1:0] ev_cnt,
  output logic [31:0]      dma_base,
  output logic [IDX_W-1:0] dma_cur,
  output logic [IDX_W-1:0] dma_last,
  output logic             dma_run,
  output logic             dma_start,
  output logic             dma_stop,
  output logic             irq
);
  localparam int SW = 5;
  localparam logic [1:0] SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2;
  localparam logic [SW-1:0] IE_KEEP = 5'b11100;

  logic [31:2]      base_q, base_n;
  logic [IDX_W-1:0] civ_q, civ_n, lvi_q, lvi_n, piv_q, piv_n;
  logic [SW-1:0]    sr_q, sr_n, cr_q, cr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             irq_q, start_q, stop_q;

  wire wr      = bus_en & bus_we;
  wire wr_base = wr & (bus_size == SZ_D) & (bus_off == 4'd0);
  wire wr_lvi  = wr & (bus_size == SZ_B) & (bus_off == 4'd5);
  wire wr_sts  = wr & ((bus_size == SZ_B) | (bus_size == SZ_W)) & (bus_off == 4'd6);
  wire wr_ctl  = wr & (bus_size == SZ_B) & (bus_off == 4'd11);
  wire cmd_rst = wr_ctl & bus_wdata[1];
  wire run_set = wr_ctl & ~bus_wdata[1] & bus_wdata[0] & ~cr_q[0];
  wire run_clr = wr_ctl & (bus_wdata[1] | ~bus_wdata[0]);
  wire restart = wr_lvi & cr_q[0] & sr_q[0];

  wire [SW-1:0] sr_clr = (wr_sts ? {bus_wdata[4:2], 2'b00} : '0) |
                         (restart ? 5'b00011 : '0);
  wire [SW-1:0] sr_set = {ev_fifoe, ev_ioc, ev_lvb, ev_lvb, ev_lvb};

  always_comb begin
    base_n = base_q;
    civ_n  = civ_q;
    lvi_n  = lvi_q;
    cnt_n  = cnt_q;
    cr_n   = cr_q;
    sr_n   = (sr_q & ~sr_clr) | sr_set;
    piv_n  = piv_q + IDX_W'(run_set | restart) + IDX_W'(ev_step);
    if (wr_base)   base_n = bus_wdata[31:2];
    if (wr_lvi)    lvi_n  = bus_wdata[IDX_W-1:0];
    if (wr_ctl)    cr_n   = bus_wdata[SW-1:0];
    if (ev_cnt_ld) cnt_n  = ev_cnt;
    if (ev_step)   civ_n  = piv_q;
    if (cmd_rst) begin
      base_n = '0;
      civ_n  = '0;
      lvi_n  = '0;
      piv_n  = '0;
      cnt_n  = '0;
      sr_n   = 5'b00001;
      cr_n   = cr_q & IE_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      civ_q   <= '0;
      lvi_q   <= '0;
      piv_q   <= '0;
      cnt_q   <= '0;
      sr_q    <= 5'b00001;
      cr_q    <= '0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      base_q  <= base_n;
      civ_q   <= civ_n;
      lvi_q   <= lvi_n;
      piv_q   <= piv_n;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      cr_q    <= cr_n;
      irq_q   <= (sr_n[2] & cr_n[2]) | (sr_n[3] & cr_n[3]);
      start_q <= run_set;
      stop_q  <= run_clr;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_size)
        SZ_D: case (bus_off)
          4'd0:    bus_rdata = {base_q, 2'b00};
          4'd4:    bus_rdata = {11'b0, sr_q, 8'(lvi_q), 8'(civ_q)};
          4'd8:    bus_rdata = {3'b0, cr_q, 8'(piv_q), 16'(cnt_q)};
          default: bus_rdata = '0;
        endcase
        SZ_W: case (bus_off)
          4'd6:    bus_rdata = {16'b0, 11'b0, sr_q};
          4'd8:    bus_rdata = {16'b0, 16'(cnt_q)};
          default: bus_rdata = '0;
        endcase
        SZ_B: case (bus_off)
          4'd4:    bus_rdata = {24'b0, 8'(civ_q)};
          4'd5:    bus_rdata = {24'b0, 8'(lvi_q)};
          4'd6:    bus_rdata = {27'b0, sr_q};
          4'd10:   bus_rdata = {24'b0, 8'(piv_q)};
          4'd11:   bus_rdata = {27'b0, cr_q};
          default: bus_rdata = '0;
        endcase
        default: bus_rdata = '0;
      endcase
    end
  end

  assign dma_base  = {base_q, 2'b00};
  assign dma_cur   = civ_q;
  assign dma_last  = lvi_q;
  assign dma_run   = cr_q[0];
  assign dma_start = start_q;
  assign dma_stop  = stop_q;
  assign irq       = irq_q;
endmodule

// File: rtl/adma_chan_regs_chk.sv
module adma_chan_regs_chk #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_wr,
  input logic [1:0]       acc_size,
  input logic [3:0]       acc_off,
  input logic             wd1,
  input logic             ev_ioc,
  input logic             ev_lvb,
  input logic [4:0]       sr,
  input logic [4:0]       cr,
  input logic [IDX_W-1:0] civ,
  input logic [IDX_W-1:0] lvi,
  input logic [IDX_W-1:0] piv,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             dma_start,
  input logic             dma_stop
);
  wire sts_wr = acc_wr && acc_off == 4'd6 && (acc_size == 2'd0 || acc_size == 2'd1);
  wire rst_wr = acc_wr && acc_off == 4'd11 && acc_size == 2'd0 && wd1;

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((sr[2] & cr[2]) | (sr[3] & cr[3])));

  p_state_bits_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !ev_lvb) |=> sr[1:0] == $past(sr[1:0]));

  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ioc && !rst_wr) |=> sr[3]);

  p_chan_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (sr == 5'b00001 && civ == '0 && lvi == '0 && piv == '0 &&
                cnt == '0 && cr == ($past(cr) & 5'b11100)));

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_start && dma_stop));

  p_start_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> cr[0]);
endmodule

bind adma_chan_regs adma_chan_regs_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(bus_en & bus_we), .acc_size(bus_size),
  .acc_off(bus_off), .wd1(bus_wdata[1]), .ev_ioc(ev_ioc), .ev_lvb(ev_lvb),
  .sr(sr_q), .cr(cr_q), .civ(civ_q), .lvi(lvi_q), .piv(piv_q), .cnt(cnt_q),
  .irq(irq), .dma_start(dma_start), .dma_stop(dma_stop));

// File: tb/sim_adma_chan_regs.sv
`timescale 1ns/1ps
module sim_adma_chan_regs;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [3:0] bus_off = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ev_step = 0, ev_ioc = 0, ev_lvb = 0, ev_fifoe = 0, ev_cnt_ld = 0;
  logic [15:0] ev_cnt = 0;
  logic [31:0] dma_base;
  logic [4:0] dma_cur, dma_last;
  logic dma_run, dma_start, dma_stop, irq;

  always #4 clk = ~clk;

  adma_chan_regs u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_base, m_civ, m_lvi, m_piv, m_sr, m_cr, m_cnt;
  bit m_irq, m_start, m_stop;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mread(int sz, int off);
    if (sz == 2) begin
      if (off == 0) return m_base;
      if (off == 4) return m_civ | (m_lvi << 8) | (m_sr << 16);
      if (off == 8) return m_cnt | (m_piv << 16) | (m_cr << 24);
    end else if (sz == 1) begin
      if (off == 6) return m_sr;
      if (off == 8) return m_cnt;
    end else if (sz == 0) begin
      if (off == 4) return m_civ;
      if (off == 5) return m_lvi;
      if (off == 6) return m_sr;
      if (off == 10) return m_piv;
      if (off == 11) return m_cr;
    end
    return 0;
  endfunction

  task automatic model_reset();
    m_base = 0; m_civ = 0; m_lvi = 0; m_piv = 0; m_sr = 1; m_cr = 0; m_cnt = 0;
    m_irq = 0; m_start = 0; m_stop = 0;
  endtask

  task automatic step();
    int sz, off, d, nsr, npiv;
    bit w;
    #1;
    if (bus_en && !bus_we) chk("R11", bus_rdata, mread(bus_size, bus_off));
    w = bus_en && bus_we; sz = bus_size; off = bus_off; d = bus_wdata;
    m_start = 0; m_stop = 0;
    if (w && sz == 0 && off == 11 && d[1]) begin
      m_base = 0; m_civ = 0; m_lvi = 0; m_piv = 0; m_cnt = 0; m_sr = 1;
      m_cr = m_cr & 'h1C; m_stop = 1;
    end else begin
      nsr = m_sr; npiv = m_piv;
      if (w && (sz == 0 || sz == 1) && off == 6) nsr = nsr & ~(d & 'h1C);
      if (w && sz == 2 && off == 0) m_base = d & 'hFFFF_FFFC;
      if (w && sz == 0 && off == 5) begin
        if ((m_cr & 1) && (m_sr & 1)) begin nsr = nsr & ~3; npiv++; end
        m_lvi = d & 31;
      end
      if (w && sz == 0 && off == 11) begin
        if (d[0] && !(m_cr & 1)) begin npiv++; m_start = 1; end
        if (!d[0]) m_stop = 1;
        m_cr = d & 31;
      end
      if (ev_ioc) nsr |= 8;
      if (ev_lvb) nsr |= 7;
      if (ev_fifoe) nsr |= 16;
      if (ev_cnt_ld) m_cnt = ev_cnt;
      if (ev_step) begin m_civ = m_piv; npiv++; end
      m_sr = nsr; m_piv = npiv % 32;
    end
    m_irq = ((m_sr & 4) && (m_cr & 4)) || ((m_sr & 8) && (m_cr & 8));
    @(posedge clk); @(negedge clk);
    chk("R2 base", dma_base, m_base);
    chk("R5 cur", dma_cur, m_civ);
    chk("R10 last", dma_last, m_lvi);
    chk("R7 run", dma_run, m_cr & 1);
    chk("R8 start", dma_start, m_start);
    chk("R8 stop", dma_stop, m_stop);
    chk("R6 irq", irq, m_irq);
    bus_en = 0; bus_we = 0; bus_wdata = 0;
    ev_step = 0; ev_ioc = 0; ev_lvb = 0; ev_fifoe = 0; ev_cnt_ld = 0;
  endtask

  task automatic wr(int sz, int off, int d);
    bus_en = 1; bus_we = 1; bus_size = 2'(sz); bus_off = 4'(off); bus_wdata = d; step();
  endtask

  task automatic rd(int sz, int off);
    bus_en = 1; bus_we = 0; bus_size = 2'(sz); bus_off = 4'(off); step();
  endtask

  task automatic peek(string req, int sz, int off, int exp);
    bus_en = 1; bus_we = 0; bus_size = 2'(sz); bus_off = 4'(off);
    #1 chk(req, bus_rdata, exp);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek("R1 status", 1, 6, 32'h1);
    peek("R1 dw4", 2, 4, 32'h0001_0000);
    peek("R1 dw8", 2, 8, 0);
    peek("R1 base", 2, 0, 0);
    // R2 base
    wr(2, 0, 32'h1234_5677);
    peek("R2 base low bits", 2, 0, 32'h1234_5674);
    wr(0, 0, 32'hFF);
    wr(1, 0, 32'hFFFF);
    peek("R2 narrow ignored", 2, 0, 32'h1234_5674);
    // R5/R6/R3 completion interrupt
    ev_ioc = 1; step();
    chk("R6 no enable", irq, 0);
    wr(0, 11, 32'h08);
    chk("R6 enabled", irq, 1);
    wr(1, 6, 32'hFFE3);
    peek("R3 zero data ignored", 0, 6, 32'h09);
    wr(1, 6, 32'h0008);
    peek("R3 w1c", 1, 6, 32'h01);
    chk("R6 cleared", irq, 0);
    // R5 last buffer, R3 ro bits, R4 priority
    wr(0, 11, 32'h04);
    ev_lvb = 1; step();
    peek("R5 lvb bits", 1, 6, 32'h07);
    wr(0, 6, 32'h03);
    peek("R3 state bits ro", 1, 6, 32'h07);
    bus_en = 1; bus_we = 1; bus_size = 0; bus_off = 6; bus_wdata = 32'h04; ev_lvb = 1; step();
    peek("R4 set wins", 0, 6, 32'h07);
    chk("R4 irq held", irq, 1);
    ev_fifoe = 1; wr(0, 11, 32'h10);
    peek("R5 fifoe", 0, 6, 32'h17);
    chk("R6 fifoe no irq", irq, 0);
    // R8 start
    wr(0, 11, 32'h0D);
    peek("R8 piv advanced", 0, 10, 1);
    wr(0, 11, 32'h0D);
    peek("R8 no re-advance", 0, 10, 1);
    ev_step = 1; ev_cnt_ld = 1; ev_cnt = 16'h1234; step();
    peek("R5 step", 2, 8, 32'h0D02_1234);
    // R10 restart while halted
    wr(0, 5, 32'hE3);
    peek("R10 restart", 2, 4, 32'h0014_0301);
    peek("R10 piv", 0, 10, 3);
    wr(0, 5, 32'h07);
    peek("R10 plain store", 0, 10, 3);
    // prefetch wrap
    for (int i = 0; i < 30; i++) begin ev_step = 1; step(); end
    peek("R5 wrap", 0, 10, 1);
    peek("R11 unmapped", 2, 12, 0);
    peek("R11 word8", 1, 8, 32'h1234);
    // R8 stop, R9 reset
    wr(0, 11, 32'h1C);
    wr(0, 11, 32'h03);
    peek("R9 dw4", 2, 4, 32'h0001_0000);
    peek("R9 dw8", 2, 8, 32'h1C00_0000);
    peek("R9 base", 2, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 11);
      ev_step = ($urandom_range(0, 3) == 0);
      ev_ioc = ($urandom_range(0, 5) == 0);
      ev_lvb = ($urandom_range(0, 9) == 0);
      ev_fifoe = ($urandom_range(0, 9) == 0);
      ev_cnt_ld = ($urandom_range(0, 7) == 0);
      ev_cnt = 16'($urandom);
      case (op)
        0: wr(0, 11, (($urandom_range(0, 15) == 0) ? 2 : 0) | ($urandom & 32'hFD));
        1: wr(0, 5, $urandom);
        2: wr($urandom_range(0, 1), 6, $urandom);
        3: wr(2, 0, $urandom);
        4, 5, 6: rd($urandom_range(0, 3), $urandom_range(0, 15));
        default: step();
      endcase
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule